// File: doc/BRIEF.md
# Fixed-Point Vector Multiply Unit

This unit runs the multiply-class instructions of a small vector coprocessor whose 128 registers are 32 bits wide. A single 32-bit command word arrives over a valid/ready handshake. The unit then walks the element vector one element per clock. It reads operands through two combinational register-file read ports and returns results through one registered write port. The register file itself sits outside the block.

Three operations are offered. The first is an element-wise product. The second is a dot product that folds all element products into a single result. The third is a scaled add: each A element is multiplied by a scalar held in register 1, and the B element is added on top. The top nibble of the command selects the operand sizes (16×16 or 32×16) and the shift: none, right by 8, or right by 16. A separate bit asks for round-to-nearest before the shift. While a command is being executed, the unit holds its ready low.

Top module: `vmul_unit`

## Requirements
- R1: Command fields are: [31:28] variant, [27:24] count, [23] round, [22:21] operation, [20:14] A base, [13:7] destination base, [6:0] B base. A command covers count+1 elements. Element i uses registers A+i, B+i and dest+i, each taken modulo 128.
- R2: Variant 0 multiplies the signed low 16 bits of A by the signed low 16 bits of B and keeps the low 32 bits of the product.
- R3: Variants 4, 5 and 6 use all 32 bits of A as a signed value, times the signed low 16 bits of B.
- R4: Variants 1 and 5 shift the product arithmetically right by 8. Variants 2 and 6 shift it right by 16.
- R5: When bit 23 is set, 2^(s-1) is added to the product before a shift of s. With no shift, bit 23 has no effect.
- R6: Operation 1 (dot) adds up the scaled products of all elements, modulo 2^32. It makes exactly one write, to the destination base, after the last element.
- R7: Operation 2 (scaled add) writes scaled(A × low16(r1)) + full 32-bit B, modulo 2^32. Register 1 is read once, before the first element.
- R8: Register 0 reads as zero whatever the read port returns for it.
- R9: No write is ever presented to address 0. This includes destinations that wrap past 127; those elements are simply dropped.
- R10: Ready is high while idle. After a command is accepted, ready stays low until the cycle that carries its final write.
- R11: During and right after reset, ready is 1 and the write enable is 0.
- R12: For a command accepted at edge E, element i is written in the cycle starting at edge E+1+i. For scaled add this becomes E+2+i. A dot result is written at E+1+count.
- R13: A command with bit 31 set is accepted, writes nothing, and leaves ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Command word present |
| instr_ready | output | 1 | Unit idle and able to take a command |
| instr | input | 32 | Command word |
| rda_addr | output | 7 | Read port A address |
| rda_data | input | DATA_W | Read port A data (same cycle) |
| rdb_addr | output | 7 | Read port B address |
| rdb_data | input | DATA_W | Read port B data (same cycle) |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 7 | Result register index |
| wr_data | output | DATA_W | Result value |

## Verification
Some faults show up at once. A corrupted element index or base address appears on the very next write as an address that breaks the +1 step, or as a value computed from the wrong registers. A wrong state shows up within one cycle as ready disagreeing with the model. Other faults take longer. A damaged dot accumulator stays hidden until its single write, count+1 cycles after acceptance. A stale scalar corrupts every scaled-add result, beginning with the first one, two cycles after acceptance. The bench therefore compares ready and the whole write port against a behavioural model on every cycle, and it also checks register contents computed by hand.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  localparam int INSTR_W = 32;
  localparam int ADDR_W  = 7;
  localparam int CNT_W   = 4;
  // command field positions (decoded by neighbours, so fixed)
  localparam int VAR_LSB = 28;
  localparam int CNT_LSB = 24;
  localparam int RND_BIT = 23;
  localparam int OP_LSB  = 21;
  localparam int SA_LSB  = 14;
  localparam int DST_LSB = 7;
  localparam int SB_LSB  = 0;
  localparam logic [ADDR_W-1:0] SCALAR_REG = ADDR_W'(1);

  typedef enum logic [1:0] {
    VOP_MUL  = 2'd0,
    VOP_DOT  = 2'd1,
    VOP_SAXP = 2'd2,
    VOP_RSVD = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAL = 2'd1,
    ST_RUN  = 2'd2
  } vst_e;

  typedef struct packed {
    logic              skip;
    logic              wide;
    logic [1:0]        shsel;
    logic [CNT_W-1:0]  cnt;
    logic              rnd;
    vop_e              op;
    logic [ADDR_W-1:0] sa;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] sb;
  } vcmd_t;
endpackage

// File: rtl/vmul_decode.sv
module vmul_decode
  import vmul_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output vcmd_t              cmd
);
  always_comb begin
    cmd.skip  = word[VAR_LSB+3];
    cmd.wide  = word[VAR_LSB+2];
    cmd.shsel = word[VAR_LSB +: 2];
    cmd.cnt   = word[CNT_LSB +: CNT_W];
    cmd.rnd   = word[RND_BIT];
    cmd.op    = vop_e'(word[OP_LSB +: 2]);
    cmd.sa    = word[SA_LSB +: ADDR_W];
    cmd.dst   = word[DST_LSB +: ADDR_W];
    cmd.sb    = word[SB_LSB +: ADDR_W];
  end
endmodule

// File: rtl/vmul_scale.sv
module vmul_scale #(
  parameter int DATA_W     = 32,
  parameter int HALF_W     = 16,
  parameter int SHIFT_STEP = 8,
  parameter int N_SHIFT    = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [HALF_W-1:0] m,
  input  logic              wide,
  input  logic [1:0]        shsel,
  input  logic              rnd,
  output logic [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + HALF_W;

  logic signed [PROD_W-1:0] a_x, m_x, prod;
  logic [DATA_W-1:0] cand [N_SHIFT];

  assign a_x  = wide ? PROD_W'($signed(a)) : PROD_W'($signed(a[HALF_W-1:0]));
  assign m_x  = PROD_W'($signed(m));
  assign prod = a_x * m_x;

  for (genvar k = 0; k < N_SHIFT; k++) begin : g_sh
    localparam int SH = k * SHIFT_STEP;
    if (SH == 0) begin : g_pass
      assign cand[k] = prod[DATA_W-1:0];
    end else begin : g_rnd
      logic signed [PROD_W-1:0] bias, sum;
      assign bias    = rnd ? (PROD_W'(1) << (SH - 1)) : '0;
      assign sum     = prod + bias;
      assign cand[k] = DATA_W'(sum >>> SH);
    end
  end

  always_comb begin
    res = cand[0];
    for (int k = 1; k < N_SHIFT; k++)
      if (shsel == 2'(k)) res = cand[k];
  end
endmodule

// File: rtl/vmul_unit.sv
module vmul_unit
  import vmul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  rda_addr,
  input  logic [DATA_W-1:0]  rda_data,
  output logic [ADDR_W-1:0]  rdb_addr,
  input  logic [DATA_W-1:0]  rdb_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);
  vcmd_t dec, cfg_q;
  vst_e  st_q, st_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [HALF_W-1:0] scal_q;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] wa_q, wa_d, dst;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [DATA_W-1:0] a_val, b_val, scaled, dot_sum;
  logic [HALF_W-1:0] mult;
  logic              accept, last, cfg_en, scal_en, run_en;

  vmul_decode u_dec (.word(instr), .cmd(dec));

  assign instr_ready = (st_q == ST_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign cfg_en      = accept && !dec.skip;
  assign scal_en     = (st_q == ST_SCAL);
  assign run_en      = (st_q == ST_RUN) || cfg_en;

  assign rda_addr = scal_en ? SCALAR_REG : cfg_q.sa + ADDR_W'(idx_q);
  assign rdb_addr = cfg_q.sb + ADDR_W'(idx_q);
  assign a_val    = (rda_addr == '0) ? '0 : rda_data;
  assign b_val    = (rdb_addr == '0) ? '0 : rdb_data;
  assign mult     = (cfg_q.op == VOP_SAXP) ? scal_q : b_val[HALF_W-1:0];
  assign dst      = cfg_q.dst + ADDR_W'(idx_q);
  assign last     = (idx_q == cfg_q.cnt);
  assign dot_sum  = acc_q + scaled;

  vmul_scale #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_scl (
    .a(a_val), .m(mult), .wide(cfg_q.wide), .shsel(cfg_q.shsel),
    .rnd(cfg_q.rnd), .res(scaled)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    acc_d = acc_q;
    we_d  = 1'b0;
    wa_d  = wa_q;
    wd_d  = wd_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_en) begin
          idx_d = '0;
          acc_d = '0;
          st_d  = (dec.op == VOP_SAXP) ? ST_SCAL : ST_RUN;
        end
      end
      ST_SCAL: st_d = ST_RUN;
      ST_RUN: begin
        if (cfg_q.op == VOP_DOT) begin
          acc_d = dot_sum;
          if (last) begin
            we_d = (cfg_q.dst != '0);
            wa_d = cfg_q.dst;
            wd_d = dot_sum;
          end
        end else begin
          we_d = (dst != '0);
          wa_d = dst;
          wd_d = (cfg_q.op == VOP_SAXP) ? scaled + b_val : scaled;
        end
        if (last) st_d  = ST_IDLE;
        else      idx_d = idx_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      we_q <= 1'b0;
    end else begin
      st_q <= st_d;
      we_q <= we_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_en)  cfg_q  <= dec;
    if (scal_en) scal_q <= a_val[HALF_W-1:0];
    if (run_en) begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
    if (we_d) begin
      wa_q <= wa_d;
      wd_q <= wd_d;
    end
  end

  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;

  AST_ZERO_DEST_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0)); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.skip) |=> !instr_ready); // R10
  AST_FOREIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.skip) |=> (instr_ready && !wr_en)); // R13
  AST_DOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_q.op == VOP_DOT) |-> instr_ready); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1))); // R1
  AST_RUN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cfg_q.op != VOP_DOT && dst != '0) |=> wr_en); // R12
endmodule

// File: tb/vmul_unit_test.sv
module vmul_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_ready;
  logic [31:0] instr;
  logic [6:0]  rda_addr, rdb_addr, wr_addr;
  logic [31:0] rda_data, rdb_data, wr_data;
  logic        wr_en;
  logic [31:0] rf [128];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vmul_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .rda_addr(rda_addr), .rda_data(rda_data), .rdb_addr(rdb_addr),
    .rdb_data(rdb_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rda_data = rf[rda_addr];
  assign rdb_data = rf[rdb_addr];

  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int vr, int rnd, int op, int cnt, int sa, int d, int sb);
    return {4'(vr), 4'(cnt), 1'(rnd), 2'(op), 7'(sa), 7'(d), 7'(sb)};
  endfunction

  function automatic logic [31:0] rdv(int x);
    return (x == 0) ? 32'h0 : rf[x];
  endfunction

  function automatic logic [31:0] scl(logic [31:0] a, logic [15:0] m, int vr, bit rnd);
    longint x, y, p;
    int sh;
    x  = (vr >= 4) ? longint'($signed(a)) : longint'($signed(a[15:0]));
    y  = longint'($signed(m));
    p  = x * y;
    sh = (vr % 4) * 8;
    if (rnd && sh > 0) p = p + (longint'(1) <<< (sh - 1));
    p = p >>> sh;
    return p[31:0];
  endfunction

  // behavioural reference, evaluated away from the active edge
  int          m_st, m_idx, m_vr, m_op, m_cnt, m_sa, m_d, m_sb;
  bit          m_rnd;
  logic [31:0] m_scal, m_acc, exp_wd;
  int          exp_wa;
  bit          exp_ready, exp_we;
  string       m_tag;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0; exp_ready = 1; exp_we = 0;
    end else begin
      chk(instr_ready == exp_ready, "R10 ready", 32'(instr_ready), 32'(exp_ready));
      chk(wr_en == exp_we, "R12 write timing", 32'(wr_en), 32'(exp_we));
      if (exp_we && wr_en) begin
        chk(wr_addr == 7'(exp_wa), "R1 write address", 32'(wr_addr), 32'(exp_wa));
        chk(wr_data == exp_wd, m_tag, wr_data, exp_wd);
      end
      exp_we = 0;
      case (m_st)
        0: if (instr_valid && !instr[31]) begin
             m_vr = int'(instr[31:28]); m_cnt = int'(instr[27:24]); m_rnd = instr[23];
             m_op = int'(instr[22:21]); m_sa = int'(instr[20:14]);
             m_d = int'(instr[13:7]); m_sb = int'(instr[6:0]);
             m_idx = 0; m_acc = 0;
             m_tag = (m_op == 1) ? "R6 dot value" : (m_op == 2) ? "R7 scaled add value" : "R2 product value";
             m_st = (m_op == 2) ? 1 : 2;
           end
        1: begin m_scal = rdv(1); m_st = 2; end
        default: begin
          logic [31:0] a, b, p;
          a = rdv((m_sa + m_idx) % 128);
          b = rdv((m_sb + m_idx) % 128);
          p = scl(a, (m_op == 2) ? m_scal[15:0] : b[15:0], m_vr, m_rnd);
          if (m_op == 1) begin
            m_acc = m_acc + p;
            if (m_idx == m_cnt && m_d != 0) begin exp_we = 1; exp_wa = m_d; exp_wd = m_acc; end
          end else if ((m_d + m_idx) % 128 != 0) begin
            exp_we = 1; exp_wa = (m_d + m_idx) % 128;
            exp_wd = (m_op == 2) ? p + b : p;
          end
          if (m_idx == m_cnt) m_st = 0; else m_idx++;
        end
      endcase
      exp_ready = (m_st == 0);
    end
  end

  task automatic issue(input logic [31:0] w);
    instr_valid = 1'b1;
    instr = w;
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic setr(input int a, input logic [31:0] v);
    rf[a] <= v;
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    for (int i = 0; i < 128; i++) rf[i] <= 32'h0;
    #1 rf[0] <= 32'h0000_1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(instr_ready == 1'b1, "R11 reset ready", 32'(instr_ready), 32'h1);
    chk(wr_en == 1'b0, "R11 reset write", 32'(wr_en), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // element-wise 16x16, back to back with a shift-16 command
    setr(10, 32'h0001_0003); setr(11, 32'h0000_FFFE); setr(12, 32'h7FFF_0100);
    setr(20, 32'h0000_0005); setr(21, 32'h1234_0007); setr(22, 32'hFFFF_FF00);
    setr(33, 32'h5555_5555);
    setr(50, 32'h0000_8000); setr(51, 32'h0000_0003);
    #1;
    issue(mk(0, 0, 0, 2, 10, 30, 20));
    issue(mk(2, 0, 0, 0, 50, 52, 51));
    settle();
    chk(rf[30] == 32'h0000_000F, "R2 elem0", rf[30], 32'h0000_000F);
    chk(rf[31] == 32'hFFFF_FFF2, "R2 elem1", rf[31], 32'hFFFF_FFF2);
    chk(rf[32] == 32'hFFFF_0000, "R2 elem2", rf[32], 32'hFFFF_0000);
    chk(rf[33] == 32'h5555_5555, "R1 count bound", rf[33], 32'h5555_5555);
    chk(rf[52] == 32'hFFFF_FFFE, "R4 shift16 negative", rf[52], 32'hFFFF_FFFE);

    // 32x16 shift 8 with and without rounding
    setr(40, 32'h0001_0080); setr(41, 32'h0000_0003);
    #1;
    issue(mk(5, 1, 0, 0, 40, 42, 41));
    issue(mk(5, 0, 0, 0, 40, 43, 41));
    issue(mk(0, 1, 0, 0, 41, 44, 41));
    settle();
    chk(rf[42] == 32'h0000_0302, "R3 wide rounded", rf[42], 32'h0000_0302);
    chk(rf[43] == 32'h0000_0301, "R4 shift8 truncated", rf[43], 32'h0000_0301);
    chk(rf[44] == 32'h0000_0009, "R5 round without shift", rf[44], 32'h0000_0009);

    // dot product over four elements
    setr(60, 1); setr(61, 2); setr(62, 3); setr(63, 4);
    setr(70, 10); setr(71, 20); setr(72, 30); setr(73, 32'h0000_FFFF);
    setr(81, 32'hA5A5_A5A5);
    #1;
    issue(mk(0, 0, 1, 3, 60, 80, 70));
    settle();
    chk(rf[80] == 32'h0000_0088, "R6 dot sum", rf[80], 32'h0000_0088);
    chk(rf[81] == 32'hA5A5_A5A5, "R6 single write", rf[81], 32'hA5A5_A5A5);

    // scaled add with scalar in register 1
    setr(1, 32'hFFFF_0004);
    setr(90, 5); setr(91, 32'h0000_FFFD);
    setr(100, 32'h1000_0000); setr(101, 7);
    #1;
    issue(mk(0, 0, 2, 1, 90, 110, 100));
    settle();
    chk(rf[110] == 32'h1000_0014, "R7 elem0", rf[110], 32'h1000_0014);
    chk(rf[111] == 32'hFFFF_FFFB, "R7 elem1", rf[111], 32'hFFFF_FFFB);

    // register 0 as source, destination wrap onto 0, foreign command
    setr(5, 9); setr(6, 32'h7777_7777);
    setr(120, 2); setr(121, 3); setr(122, 5); setr(123, 7);
    setr(35, 32'h3333_3333);
    #1;
    issue(mk(0, 0, 0, 0, 0, 6, 5));
    issue(mk(0, 0, 0, 1, 120, 127, 122));
    issue(mk(8, 0, 0, 0, 5, 35, 5));
    settle();
    chk(rf[6] == 32'h0, "R8 zero source", rf[6], 32'h0);
    chk(rf[127] == 32'h0000_000A, "R1 last register", rf[127], 32'h0000_000A);
    chk(rf[0] == 32'h0000_1234, "R9 no write to zero", rf[0], 32'h0000_1234);
    chk(rf[35] == 32'h3333_3333, "R13 foreign command", rf[35], 32'h3333_3333);

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule